// File: doc/BRIEF.md
# Periodic Audio Sample Fetcher

This block plays back a stretch of 8-bit audio samples from memory without help from the CPU. Software programs a start address and a length, then sets the enable bit in the control register. A period counter then produces one sample slot every `PERIOD` clock cycles, 246 by default, where one clock is one CPU cycle. In each slot the block reads one byte from memory and drops its least significant bit. The remaining seven bits go to the DAC level output.

The length counter is decremented once per slot. In the first slot after the length has run out, the block fetches nothing. Instead it clears its enable and raises a sticky interrupt flag. That flag drives the IRQ line and also appears as the top bit of the status word, whose lower seven bits are passed through from an external status source. The next control write clears the flag.

Memory reads use a valid/ready request and a later response. Slot timing never waits for memory. If a slot arrives while the previous fetch is still outstanding, that slot's sample is skipped, but the slot still counts against the length.

Top module: `pcm_dma`

## Requirements
- R1: After reset, irq is low, `dac_level` is 0, `mem_req_valid` is low, and `status_out` bit 7 is 0.
- R2: A write with `wr_sel` = 0 sets the next fetch address to `wr_data` shifted left by 6 bits.
- R3: A write with `wr_sel` = 1 sets the sample count to (`wr_data` << 4) + 1. Exactly that many slots fetch, and the slot after them raises the interrupt.
- R4: A write with `wr_sel` = 2 and `wr_data` bit 4 = 1 enables the block. Slots then fall every `PERIOD` cycles counted from that write: the first request is visible `PERIOD` cycles after it, and irq is visible (count + 1) × `PERIOD` cycles after it.
- R5: When a response arrives, `dac_level` takes bits 7:1 of the returned byte. `dac_level` changes at no other time.
- R6: Consecutive fetches use consecutive addresses, and the address wraps from 0x7FFF to 0 within its 15 bits.
- R7: When the count runs out, irq and `status_out` bit 7 go high and stay high, and no further request is issued.
- R8: Any write with `wr_sel` = 2 clears the interrupt flag. If bit 4 of that write is 0, the block is disabled and issues no requests.
- R9: `status_out` is {interrupt flag, `ext_status[6:0]`}.
- R10: A request holds its valid and address until ready. The slot timer keeps running while a fetch is outstanding. A slot that falls during an outstanding fetch decrements the count but fetches nothing and does not advance the address.
- R11: Disabling the block does not cancel an outstanding fetch. Its response still updates `dac_level`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock; one cycle is one slot-timer step |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 address, 1 length, 2 control, 3 ignored |
| wr_data | input | 8 | Register write data |
| ext_status | input | 7 | Status bits passed through to `status_out[6:0]` |
| status_out | output | 8 | Interrupt flag in bit 7, `ext_status` below it |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 15 | Memory read byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 8 | Read data byte |
| dac_level | output | 7 | Halved sample level for the DAC |
| irq | output | 1 | Interrupt request, high while the flag is set |

## Verification
Two situations are hard to reach from the ports: a slot falling while a fetch is still outstanding, and the 15-bit address wrap. For the first, the bench withholds `mem_req_ready` for three slot periods, then checks that exactly two samples are lost, the interrupt still arrives on schedule, and the addresses remain contiguous. For the wrap, the bench uses a short period and starts at the highest address the register can load. It chains five maximum-length runs without rewriting the address, until a fetch at address 0 follows one at 0x7FFF.

// File: rtl/pcm_dma_pkg.sv
package pcm_dma_pkg;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_LEN  = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int NUM_LOADS   = 3;
  localparam int CTRL_EN_BIT = 4;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_REQ  = 2'd1,
    FS_WAIT = 2'd2
  } fetch_st_e;

endpackage

// File: rtl/pcm_dma_regdec.sv
module pcm_dma_regdec
  import pcm_dma_pkg::*;
(
  input  logic                 wr_en,
  input  logic [1:0]           wr_sel,
  output logic [NUM_LOADS-1:0] ld
);

  // one load strobe per writable register, indexed by select code
  for (genvar g = 0; g < NUM_LOADS; g++) begin : g_ld
    assign ld[g] = wr_en && (wr_sel == 2'(g));
  end

endmodule

// File: rtl/pcm_dma_pacer.sv
module pcm_dma_pacer
  import pcm_dma_pkg::*;
#(
  parameter int PERIOD    = 246,
  parameter int DATA_W    = 8,
  parameter int LEN_SHIFT = 4,
  parameter int CNT_W     = 8,
  parameter int REM_W     = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_len,
  input  logic              ld_ctrl,
  input  logic [DATA_W-1:0] wdata,
  output logic              fetch_go,
  output logic              irq
);

  logic             en_q, en_d;
  logic             irq_q, irq_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [REM_W-1:0] rem_q, rem_d;
  logic [REM_W-1:0] len_val;
  logic             slot;
  logic             rem_left;

  assign len_val  = {1'b0, wdata, {LEN_SHIFT{1'b0}}} + 1'b1;
  assign slot     = en_q && !ld_ctrl && (cnt_q == CNT_W'(1));
  assign rem_left = !rem_q[REM_W-1] && (rem_q != '0);

  always_comb begin
    en_d     = en_q;
    irq_d    = irq_q;
    cnt_d    = cnt_q;
    rem_d    = rem_q;
    fetch_go = 1'b0;
    if (ld_ctrl) begin
      en_d  = wdata[CTRL_EN_BIT];
      irq_d = 1'b0;
      if (wdata[CTRL_EN_BIT]) cnt_d = CNT_W'(PERIOD);
    end else if (en_q) begin
      if (slot) begin
        cnt_d = CNT_W'(PERIOD);
        if (rem_left) begin
          rem_d    = rem_q - 1'b1;
          fetch_go = 1'b1;
        end else begin
          rem_d = '1;
          irq_d = 1'b1;
          en_d  = 1'b0;
        end
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
    if (ld_len) rem_d = len_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      irq_q <= 1'b0;
      cnt_q <= CNT_W'(PERIOD);
      rem_q <= '0;
    end else begin
      en_q  <= en_d;
      irq_q <= irq_d;
      cnt_q <= cnt_d;
      rem_q <= rem_d;
    end
  end

  assign irq = irq_q;

endmodule

// File: rtl/pcm_dma_fetch.sv
module pcm_dma_fetch
  import pcm_dma_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int DATA_W     = 8,
  parameter int ADDR_SHIFT = 6,
  parameter int DAC_W      = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_go,
  input  logic              ld_addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic [DAC_W-1:0]  dac_level
);

  fetch_st_e         st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ADDR_W-1:0] req_addr_q, req_addr_d;
  logic [DAC_W-1:0]  dac_q, dac_d;
  logic              dac_en;
  logic              rsp_lsb_unused;

  assign rsp_lsb_unused = mem_rsp_data[0];

  always_comb begin
    st_d       = st_q;
    addr_d     = addr_q;
    req_addr_d = req_addr_q;
    dac_d      = dac_q;
    dac_en     = 1'b0;
    unique case (st_q)
      FS_IDLE: if (fetch_go) begin
        st_d       = FS_REQ;
        req_addr_d = addr_q;
        addr_d     = addr_q + 1'b1;
      end
      FS_REQ:  if (mem_req_ready) st_d = FS_WAIT;
      FS_WAIT: if (mem_rsp_valid) begin
        st_d   = FS_IDLE;
        dac_en = 1'b1;
        dac_d  = mem_rsp_data[DATA_W-1:1];
      end
      default: st_d = FS_IDLE;
    endcase
    if (ld_addr) addr_d = ADDR_W'({wdata, {ADDR_SHIFT{1'b0}}});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= FS_IDLE;
      addr_q     <= '0;
      req_addr_q <= '0;
    end else begin
      st_q       <= st_d;
      addr_q     <= addr_d;
      req_addr_q <= req_addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dac_q <= '0;
    else if (dac_en) dac_q <= dac_d;
  end

  assign mem_req_valid = (st_q == FS_REQ);
  assign mem_req_addr  = req_addr_q;
  assign dac_level     = dac_q;

endmodule

// File: rtl/pcm_dma.sv
module pcm_dma
  import pcm_dma_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int DATA_W     = 8,
  parameter int PERIOD     = 246,
  parameter int ADDR_SHIFT = 6,
  parameter int LEN_SHIFT  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-2:0] ext_status,
  output logic [DATA_W-1:0] status_out,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic [DATA_W-2:0] dac_level,
  output logic              irq
);

  localparam int CNT_W = $clog2(PERIOD + 1);
  localparam int REM_W = DATA_W + LEN_SHIFT + 1;
  localparam int DAC_W = DATA_W - 1;

  // reset asserts at once, releases on the second clock edge
  logic [1:0]           rst_sync_q;
  logic                 core_rst_n;
  logic [NUM_LOADS-1:0] ld;
  logic                 fetch_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  pcm_dma_regdec u_regdec (
    .wr_en  (wr_en),
    .wr_sel (wr_sel),
    .ld     (ld)
  );

  pcm_dma_pacer #(
    .PERIOD    (PERIOD),
    .DATA_W    (DATA_W),
    .LEN_SHIFT (LEN_SHIFT),
    .CNT_W     (CNT_W),
    .REM_W     (REM_W)
  ) u_pacer (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .ld_len   (ld[SEL_LEN]),
    .ld_ctrl  (ld[SEL_CTRL]),
    .wdata    (wr_data),
    .fetch_go (fetch_go),
    .irq      (irq)
  );

  pcm_dma_fetch #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .ADDR_SHIFT (ADDR_SHIFT),
    .DAC_W      (DAC_W)
  ) u_fetch (
    .clk           (clk),
    .rst_n         (core_rst_n),
    .fetch_go      (fetch_go),
    .ld_addr       (ld[SEL_ADDR]),
    .wdata         (wr_data),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .dac_level     (dac_level)
  );

  assign status_out = {irq, ext_status};

endmodule

// File: rtl/pcm_dma_chk.sv
module pcm_dma_chk
  import pcm_dma_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        wr_sel,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid,
  input logic [DATA_W-2:0] dac_level,
  input logic              irq
);

  logic ctrl_wr;
  assign ctrl_wr = wr_en && (wr_sel == SEL_CTRL);

  // R10: a stalled request keeps valid and address
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R5: the level moves only on a response
  assert_dac_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rsp_valid |=> $stable(dac_level));

  // R8: a control write clears the flag
  assert_ctrl_clears_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> !irq);

  // R7: the flag is sticky until a control write
  assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !ctrl_wr |=> irq);

  // R7: no new request once exhausted
  assert_no_req_after_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !mem_req_valid && !ctrl_wr |=> !mem_req_valid);

endmodule

bind pcm_dma pcm_dma_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_en         (wr_en),
  .wr_sel        (wr_sel),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .dac_level     (dac_level),
  .irq           (irq)
);

// File: tb/pcm_dma_bench.sv
module pcm_dma_bench;

  localparam int P = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [7:0]  wr_data = 8'd0;
  logic [6:0]  ext_status = 7'h15;
  logic [7:0]  status_out;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [14:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [7:0]  mem_rsp_data = 8'd0;
  logic [6:0]  dac_level;
  logic        irq;

  always #10 clk = ~clk;

  pcm_dma #(.PERIOD(P)) u_pcm_dma (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ext_status(ext_status), .status_out(status_out),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .dac_level(dac_level), .irq(irq)
  );

  int nchk = 0;
  int nfail = 0;

  function automatic logic [7:0] memf(input logic [14:0] a);
    logic [14:0] t;
    t = a * 15'd37;
    return t[7:0] ^ {1'b0, a[14:8]} ^ 8'h5A;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model and request monitor
  logic [14:0] exp_addr = '0, first_addr = '0, last_addr = '0, pend_addr = '0;
  int acc_cnt = 0, addr_err = 0;
  bit pend = 1'b0, got_first = 1'b0, saw_wrap = 1'b0;

  always @(negedge clk) begin
    mem_rsp_valid = pend;
    mem_rsp_data  = memf(pend_addr);
    pend = 1'b0;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (mem_req_addr != exp_addr) addr_err++;
      if (mem_req_addr == 15'd0 && exp_addr == 15'd0) saw_wrap = 1'b1;
      if (!got_first) begin first_addr = mem_req_addr; got_first = 1'b1; end
      last_addr = mem_req_addr;
      exp_addr  = mem_req_addr + 15'd1;
      acc_cnt++;
      pend = 1'b1;
      pend_addr = mem_req_addr;
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clear_stats(input logic [14:0] start);
    acc_cnt = 0; addr_err = 0; got_first = 1'b0; exp_addr = start;
  endtask

  task automatic set_ready(input logic v);
    @(posedge clk);
    #2 mem_req_ready = v;
  endtask

  task automatic run(input int limit, output int n_irq, output int n_req);
    n_irq = -1; n_req = -1;
    for (int n = 1; n <= limit; n++) begin
      @(negedge clk);
      if (n_req < 0 && mem_req_valid) n_req = n;
      if (irq) begin n_irq = n; break; end
    end
  endtask

  // address byte, length byte
  localparam logic [15:0] VEC [5] = '{16'h0000, 16'h1201, 16'hA503, 16'h3C00, 16'hFF02};

  initial begin
    repeat (195000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int ni, nr, len;
    logic [14:0] base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 irq after reset", int'(irq), 0);
    chk("R1 dac after reset", int'(dac_level), 0);
    chk("R1 no request after reset", int'(mem_req_valid), 0);
    chk("R1 R9 status after reset", int'(status_out), int'({1'b0, ext_status}));

    // R8: control write without bit 4 never starts fetching
    clear_stats(15'h0040);
    wr(2'd0, 8'h01); wr(2'd1, 8'h00); wr(2'd2, 8'hEF);
    repeat (3 * P) @(negedge clk);
    chk("R8 disabled no fetch", acc_cnt, 0);
    chk("R8 disabled no irq", int'(irq), 0);

    for (int v = 0; v < 5; v++) begin
      base = {1'b0, VEC[v][15:8], 6'b0};
      len  = (int'(VEC[v][7:0]) << 4) + 1;
      ext_status = VEC[v][14:8] ^ 7'h2A;
      clear_stats(base);
      wr(2'd0, VEC[v][15:8]);
      wr(2'd1, VEC[v][7:0]);
      wr(2'd2, 8'h10);
      run((len + 1) * P + 20, ni, nr);
      chk("R4 first request delay", nr, P);
      chk("R3 R4 irq delay", ni, (len + 1) * P);
      chk("R3 fetch count", acc_cnt, len);
      chk("R2 start address", int'(first_addr), int'(base));
      chk("R6 contiguous addresses", addr_err, 0);
      chk("R5 dac holds last byte halved", int'(dac_level), int'(memf(last_addr) >> 1));
      chk("R9 R7 status with flag", int'(status_out), int'({1'b1, ext_status}));
      repeat (3 * P) @(negedge clk);
      chk("R7 no fetch after exhaustion", acc_cnt, len);
      chk("R7 flag sticky", int'(irq), 1);
      wr(2'd2, 8'h00);
      chk("R8 control write clears flag", int'(status_out[7]), 0);
    end

    // R10 and R11: one fetch stalled past exhaustion, then disabled
    set_ready(1'b0);
    clear_stats(15'h0800);
    wr(2'd0, 8'h20); wr(2'd1, 8'h00); wr(2'd2, 8'h10);
    run(4 * P, ni, nr);
    chk("R10 slots continue while stalled", ni, 2 * P);
    chk("R10 request held", int'(mem_req_valid), 1);
    chk("R10 held address", int'(mem_req_addr), 'h800);
    wr(2'd2, 8'h00);
    set_ready(1'b1);
    repeat (4) @(negedge clk);
    chk("R11 outstanding fetch completes", acc_cnt, 1);
    chk("R11 dac after disable", int'(dac_level), int'(memf(15'h0800) >> 1));
    chk("R8 flag cleared", int'(irq), 0);

    // R10: slots during a stall are lost without moving the address
    set_ready(1'b0);
    clear_stats(15'h0C00);
    wr(2'd0, 8'h30); wr(2'd1, 8'h01); wr(2'd2, 8'h10);
    fork
      run(18 * P + 20, ni, nr);
      begin
        repeat (3 * P + 1) @(posedge clk);
        #2 mem_req_ready = 1'b1;
      end
    join
    chk("R10 irq time unchanged by stall", ni, 18 * P);
    chk("R10 two slots dropped", acc_cnt, 15);
    chk("R10 R6 addresses contiguous", addr_err, 0);
    chk("R10 last address", int'(last_addr), 'hC00 + 14);
    wr(2'd2, 8'h00);

    // R6: chained maximum runs cross 0x7FFF
    clear_stats(15'h3FC0);
    saw_wrap = 1'b0;
    wr(2'd0, 8'hFF);
    for (int r = 0; r < 5; r++) begin
      wr(2'd1, 8'hFF);
      wr(2'd2, 8'h10);
      run(4082 * P + 20, ni, nr);
      chk("R3 maximum length run", ni, 4082 * P);
      wr(2'd2, 8'h00);
    end
    chk("R6 address wrapped to zero", int'(saw_wrap), 1);
    chk("R6 no address gap across runs", addr_err, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule